// File: doc/BRIEF.md
# Keyed Register Write Protection Unit

This block stands between a simple register write bus (address, data, strobe) and a bank of configuration registers. It guards that bank against stray software writes. The bank has ten guarded configuration registers: mode, two channel-sequence, channel-enable, channel-disable, extended-mode, compare-window, gain, offset and analog-control. It also has two unguarded data registers. While protection is on, any write aimed at a guarded register is dropped. A sticky violation flag is then raised, and the word address of the dropped write is logged. When several writes are dropped, only the most recent address is kept.

Protection is switched on or off through a control register. That register accepts a write only when the data carries the access key 0x414443 in bits [31:8]. Without the key, the write has no effect at all, so the control register guards itself. A keyed write also wipes the violation log. A read-only status register returns the flag and the logged address. A combinational read port returns any mapped register.

The guard is a three-state machine:
- `ST_OPEN`: protection off, no violation.
- `ST_GUARDED`: protection on, no violation.
- `ST_TRIPPED`: protection on, violation logged.

Its transitions are:
- `T_KEY_ON`: keyed write with bit 0 set, from any state to `ST_GUARDED`.
- `T_KEY_OFF`: keyed write with bit 0 clear, from any state to `ST_OPEN`.
- `T_TRIP`: guarded write attempt, from `ST_GUARDED` to `ST_TRIPPED`.
- `T_RETRIP`: guarded write attempt in `ST_TRIPPED`, which stays in `ST_TRIPPED` and overwrites the logged address.

Any other cycle holds the state.

Top module: `wprot_unit`

## Requirements
- R1: After reset, every storage register, the control register read-back and the status register read 0. Protection is off.
- R2: A write to an unguarded data register (word addresses 10 and 11) is always stored, whatever the protection state.
- R3: A write to a guarded register (word addresses 0 to 9) is stored while protection is off.
- R4: While protection is on, a write to a guarded register leaves its contents unchanged and raises the violation flag one clock after the strobe.
- R5: Each dropped write logs its 16-bit word address. The newest dropped write overwrites any older log entry.
- R6: A write to the control register (word address 0x20) is keyed when data bits [31:8] equal 0x414443. It sets protection to data bit 0. Reading the control register returns that bit at bit 0 and zero elsewhere.
- R7: A control register write with any other key value changes neither protection, the flag nor the logged address.
- R8: A keyed write clears the violation flag and the logged address to 0.
- R9: Writes to the status register (word address 0x21) and to unmapped addresses change nothing. Reads of unmapped addresses return 0.
- R10: The status register read returns the flag at bit 0 and the logged address at bits [23:8]. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 16 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 16 | Word address of the read |
| rd_data | output | 32 | Combinational read data |

## Verification
Directed writes cover every transition in turn:
- guarded writes with protection off, then on;
- two dropped writes in a row, which separates `T_TRIP` from `T_RETRIP` through the logged address;
- wrong-key writes in both `ST_OPEN` and `ST_TRIPPED`, which shows that a bad key leaves the state alone;
- writes to the status and unmapped addresses.

Random writes then spread over guarded, unguarded, control, status and unmapped addresses. About a third of the control writes carry the right key. Each write is followed by a read-back of the target and of the status register, so a mis-gated store, a missed flag or a stale log entry shows up in the cycle after the write.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
    localparam int          DATA_W = 32;
    localparam int          KEY_W  = 24;
    localparam logic [23:0] ACCESS_KEY = 24'h414443;

    typedef enum logic [1:0] {
        ST_OPEN    = 2'd0,
        ST_GUARDED = 2'd1,
        ST_TRIPPED = 2'd2
    } guard_state_e;
endpackage

// File: rtl/wprot_decode.sv
module wprot_decode #(
    parameter int ADDR_W    = 16,
    parameter int NUM_PROT  = 10,
    parameter int NUM_OPEN  = 2,
    parameter int CTRL_ADDR = 32,
    parameter int STAT_ADDR = 33,
    localparam int NUM_REGS = NUM_PROT + NUM_OPEN,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_prot_o,
    output logic              hit_open_o,
    output logic              hit_ctrl_o,
    output logic              hit_stat_o,
    output logic [IDX_W-1:0]  idx_o
);
    always_comb begin
        hit_prot_o = (addr_i < ADDR_W'(NUM_PROT));
        hit_open_o = (addr_i >= ADDR_W'(NUM_PROT)) && (addr_i < ADDR_W'(NUM_REGS));
        hit_ctrl_o = (addr_i == ADDR_W'(CTRL_ADDR));
        hit_stat_o = (addr_i == ADDR_W'(STAT_ADDR));
        idx_o      = addr_i[IDX_W-1:0];
    end
endmodule

// File: rtl/wprot_store.sv
module wprot_store #(
    parameter int NUM_REGS = 12,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] regs_o [NUM_REGS]
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_o[g] <= '0;
            end else if (we_i && (idx_i == IDX_W'(g))) begin
                regs_o[g] <= wdata_i;
            end
        end
    end
endmodule

// File: rtl/wprot_fsm.sv
module wprot_fsm
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              keyed_i,
    input  logic              key_en_i,
    input  logic              attempt_i,
    input  logic [ADDR_W-1:0] attempt_addr_i,
    output logic              prot_on_o,
    output logic              flag_o,
    output logic [ADDR_W-1:0] src_o
);
    guard_state_e      state_q, state_d;
    logic [ADDR_W-1:0] src_q, src_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            src_q   <= '0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        if (keyed_i) begin
            state_d = key_en_i ? ST_GUARDED : ST_OPEN;   // T_KEY_ON / T_KEY_OFF
            src_d   = '0;
        end else if (attempt_i) begin
            unique case (state_q)
                ST_OPEN: ;
                ST_GUARDED, ST_TRIPPED: begin                // T_TRIP / T_RETRIP
                    state_d = ST_TRIPPED;
                    src_d   = attempt_addr_i;
                end
                default: state_d = ST_OPEN;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_GUARDED: begin prot_on_o = 1'b1; flag_o = 1'b0; end
            ST_TRIPPED: begin prot_on_o = 1'b1; flag_o = 1'b1; end
            default:    begin prot_on_o = 1'b0; flag_o = 1'b0; end
        endcase
        src_o = src_q;
    end

    assert_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (attempt_i && prot_on_o && !keyed_i) |=> flag_o);
    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (attempt_i && prot_on_o && !keyed_i) |=> (src_o == $past(attempt_addr_i)));
    assert_key_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        keyed_i |=> (prot_on_o == $past(key_en_i)));
    assert_key_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        keyed_i |=> (!flag_o && src_o == '0));
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!keyed_i && !(attempt_i && prot_on_o)) |=> ($stable(state_q) && $stable(src_o)));
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
    import wprot_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_PROT  = 10,
    parameter int NUM_OPEN  = 2,
    parameter int CTRL_ADDR = 32,
    parameter int STAT_ADDR = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);
    localparam int NUM_REGS = NUM_PROT + NUM_OPEN;
    localparam int IDX_W    = $clog2(NUM_REGS);

    logic             w_prot, w_open, w_ctrl, w_stat;
    logic             r_prot, r_open, r_ctrl, r_stat;
    logic [IDX_W-1:0] w_idx, r_idx;
    logic             keyed, attempt, store_we;
    logic             prot_on, flag;
    logic [ADDR_W-1:0] src;
    logic [31:0]      store_q [NUM_REGS];

    wprot_decode #(.ADDR_W(ADDR_W), .NUM_PROT(NUM_PROT), .NUM_OPEN(NUM_OPEN),
                   .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)) u_wdec (
        .addr_i(wr_addr), .hit_prot_o(w_prot), .hit_open_o(w_open),
        .hit_ctrl_o(w_ctrl), .hit_stat_o(w_stat), .idx_o(w_idx));

    wprot_decode #(.ADDR_W(ADDR_W), .NUM_PROT(NUM_PROT), .NUM_OPEN(NUM_OPEN),
                   .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)) u_rdec (
        .addr_i(rd_addr), .hit_prot_o(r_prot), .hit_open_o(r_open),
        .hit_ctrl_o(r_ctrl), .hit_stat_o(r_stat), .idx_o(r_idx));

    always_comb begin
        keyed    = wr_en && w_ctrl && (wr_data[31:8] == ACCESS_KEY);
        attempt  = wr_en && w_prot;
        store_we = wr_en && (w_open || (w_prot && !prot_on));
    end

    wprot_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .keyed_i(keyed), .key_en_i(wr_data[0]),
        .attempt_i(attempt), .attempt_addr_i(wr_addr),
        .prot_on_o(prot_on), .flag_o(flag), .src_o(src));

    wprot_store #(.NUM_REGS(NUM_REGS), .DATA_W(32)) u_store (
        .clk(clk), .rst_n(rst_n), .we_i(store_we), .idx_i(w_idx),
        .wdata_i(wr_data), .regs_o(store_q));

    always_comb begin
        rd_data = '0;
        if (r_prot || r_open) rd_data = store_q[r_idx];
        else if (r_ctrl)      rd_data = {31'd0, prot_on};
        else if (r_stat)      rd_data = {8'd0, 16'(src), 7'd0, flag};
    end

    assert_open_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w_open) |=> (store_q[$past(w_idx)] == $past(wr_data)));
    assert_unguarded_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w_prot && !prot_on) |=> (store_q[$past(w_idx)] == $past(wr_data)));
    assert_blocked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w_prot && prot_on) |=> (store_q[$past(w_idx)] == $past(store_q[w_idx])));
endmodule

// File: tb/sim_wprot_unit.sv
`timescale 1ns/1ps
module sim_wprot_unit;
    localparam logic [15:0] CTRL = 16'h20;
    localparam logic [15:0] STAT = 16'h21;
    localparam logic [23:0] KEY  = 24'h414443;

    logic        clk = 0, rst_n = 0, wr_en = 0;
    logic [15:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    int checks = 0, fails = 0;
    bit done = 0;

    logic [31:0] m_mem [12];
    logic        m_en, m_flag;
    logic [15:0] m_src;

    always #2.5 clk = ~clk;

    wprot_unit u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                   .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

    function automatic logic [31:0] model_read(logic [15:0] a);
        if (a < 16'd12)  return m_mem[a[3:0]];
        if (a == CTRL)   return {31'd0, m_en};
        if (a == STAT)   return {8'd0, m_src, 7'd0, m_flag};
        return 32'd0;
    endfunction

    function automatic string tag_of(logic [15:0] a);
        if (a < 16'd10) return m_en ? "R4" : "R3";
        if (a < 16'd12) return "R2";
        if (a == CTRL)  return "R6";
        return "R9";
    endfunction

    task automatic model_write(logic [15:0] a, logic [31:0] d);
        if (a == CTRL) begin
            if (d[31:8] == KEY) begin m_en = d[0]; m_flag = 0; m_src = 0; end
        end else if (a < 16'd10) begin
            if (m_en) begin m_flag = 1; m_src = a; end
            else m_mem[a[3:0]] = d;
        end else if (a < 16'd12) begin
            m_mem[a[3:0]] = d;
        end
    endtask

    task automatic do_write(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        model_write(a, d);
    endtask

    task automatic check_read(logic [15:0] a, string tag);
        logic [31:0] exp;
        rd_addr = a;
        #1;
        exp = model_read(a);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rd_data, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 12; i++) m_mem[i] = '0;
        m_en = 0; m_flag = 0; m_src = 0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 12; i++) check_read(16'(i), "R1");
        check_read(CTRL, "R1");
        check_read(STAT, "R1");
        // R3: guarded writes pass while off
        do_write(16'd0, 32'hA5A5_0001); check_read(16'd0, "R3");
        do_write(16'd4, 32'h1234_5678); check_read(16'd4, "R3");
        do_write(16'd9, 32'hFFFF_0000); check_read(16'd9, "R3");
        // R7: wrong key in open state
        do_write(CTRL, {24'h414444, 8'h01}); check_read(CTRL, "R7");
        do_write(16'd7, 32'h0000_0777); check_read(16'd7, "R7");
        // R6: keyed enable
        do_write(CTRL, {KEY, 8'h01}); check_read(CTRL, "R6");
        // R4, R5, R10: blocked write logged
        do_write(16'd4, 32'hDEAD_BEEF); check_read(16'd4, "R4");
        check_read(STAT, "R10");
        if (m_src != 16'd4) $display("model inconsistency");
        do_write(16'd9, 32'h0BAD_0BAD); check_read(16'd9, "R4");
        check_read(STAT, "R5");
        // R2: open register passes under protection
        do_write(16'd10, 32'hCAFE_F00D); check_read(16'd10, "R2");
        do_write(16'd11, 32'h0F0F_0F0F); check_read(16'd11, "R2");
        // R7: wrong key while tripped
        do_write(CTRL, {24'h000000, 8'h00}); check_read(CTRL, "R7");
        check_read(STAT, "R7");
        // R9: status and unmapped writes ignored
        do_write(STAT, 32'hFFFF_FFFF); check_read(STAT, "R9");
        do_write(16'h30, 32'h1111_2222); check_read(16'h30, "R9");
        // R8: keyed write clears log
        do_write(CTRL, {KEY, 8'h01}); check_read(STAT, "R8");
        check_read(CTRL, "R8");
        // keyed disable, guarded writes pass again
        do_write(CTRL, {KEY, 8'h00}); check_read(CTRL, "R6");
        do_write(16'd2, 32'h2222_3333); check_read(16'd2, "R3");

        // random phase
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            logic [31:0] d;
            string t;
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 5)       a = 16'($urandom_range(0, 9));
            else if (sel == 5) a = 16'($urandom_range(10, 11));
            else if (sel < 8)  a = CTRL;
            else if (sel == 8) a = STAT;
            else               a = 16'($urandom_range(34, 200));
            d = $urandom;
            if (a == CTRL && $urandom_range(0, 2) == 0) d[31:8] = KEY;
            t = tag_of(a);
            do_write(a, d);
            check_read(a, t);
            check_read(STAT, "R10");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule